// File: doc/BRIEF.md
# Vector Mask Byte Transfer Sequencer

This block drives the memory side of a vector mask load or a vector mask store. A one-cycle start pulse hands it four things: the direction, a base address, the active vector length `vl` (counted in mask bits) and a resume index `vstart`. For these operations `vstart` counts bytes, not elements. The block then walks the covered bytes in ascending order and issues one byte-wide memory request per accepted handshake.

On a load, each request carries its byte index as a tag. Each returned byte goes to the destination register byte that the tag names, through a byte write port. On a store, the outgoing byte is taken from the source register image at the current index.

A mask of `vl` bits occupies ceil(vl/8) bytes. Only bytes from `vstart` up to that limit move. When the range is empty, or `vstart` lies past the register, the block issues no request. In every case the operation ends with the resume index at zero and a one-cycle `done` pulse.

Top module: `vmask_seq`

## Requirements
- R1: The number of byte requests accepted equals ceil(vl/8) − vstart, where ceil(vl/8) = (vl+7)>>3; for example, vl=11 covers bytes 0 and 1.
- R2: Requests go out in ascending byte order. The request for byte i has address base+i and tag i, so the first request has address base+vstart.
- R3: If vstart ≥ VLEN/8, no request is issued, and `done` is high in the cycle after the start pulse.
- R4: If vstart ≥ ceil(vl/8) (this includes vl=0), no request is issued, and `done` is high in the cycle after the start pulse.
- R5: On a load, a response drives `dst_we`=1 in the same cycle, with `dst_idx` = `rsp_tag` and `dst_byte` = `rsp_data`. `dst_we` is 0 in every other cycle, so destination bytes outside the covered range keep their contents.
- R6: On a store, every request has `req_we`=1, `req_be`=1, and write data equal to source byte i (bits 8i+7..8i of `src_vreg`). No byte outside the covered range is written. On a load, `req_we`=0 and `req_be`=1.
- R7: While `req_valid` is high and `req_ready` is low, the request stays valid and its address does not change in the next cycle.
- R8: While busy after a transfer starts, `vstart_out` equals the captured vstart. `done` is a single-cycle pulse, and `vstart_out` is 0 whenever `done` is high.
- R9: A start pulse that arrives while busy has no effect on the running transfer.
- R10: A synchronous active-high reset returns the block to idle, with `busy`, `done`, `req_valid` and `vstart_out` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled when idle |
| op_store | input | 1 | 1 = store to memory, 0 = load into register |
| base_addr | input | AW | Byte address of mask byte 0 |
| vl | input | $clog2(VLEN+1) | Active vector length in mask bits |
| vstart_in | input | $clog2(VLEN/8)+1 | Resume point in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| vstart_out | output | $clog2(VLEN/8)+1 | Current resume index, cleared at completion |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts request |
| req_we | output | 1 | Request is a write |
| req_be | output | 1 | Byte enable |
| req_addr | output | AW | Request byte address |
| req_tag | output | $clog2(VLEN/8) | Byte index carried with the request |
| req_wdata | output | 8 | Store data byte |
| rsp_valid | input | 1 | Load response valid |
| rsp_tag | input | $clog2(VLEN/8) | Byte index returned with the data |
| rsp_data | input | 8 | Returned byte |
| src_vreg | input | VLEN | Source register image for stores |
| dst_we | output | 1 | Destination byte write enable |
| dst_idx | output | $clog2(VLEN/8) | Destination byte index |
| dst_byte | output | 8 | Destination byte value |

## Verification
On a load, the write-back of an earlier returned byte and the issue of a later request often fall in the same cycle, each with its own index. The bench provokes this with a memory model that answers one cycle after acceptance and holds some responses back, while the ready line stays high or toggles. It judges each such cycle by checking the write port against the response tag and data, and the request address against the next expected byte, independently of each other. It also counts how many cycles had both at once.

// File: rtl/vmask_seq.sv
module vmask_seq #(
  parameter int VLEN = 128,
  parameter int AW   = 64,
  localparam int NB  = VLEN / 8,
  localparam int IW  = $clog2(NB),
  localparam int VSW = IW + 1,
  localparam int VLW = $clog2(VLEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            op_store,
  input  logic [AW-1:0]   base_addr,
  input  logic [VLW-1:0]  vl,
  input  logic [VSW-1:0]  vstart_in,
  output logic            busy,
  output logic            done,
  output logic [VSW-1:0]  vstart_out,
  output logic            req_valid,
  input  logic            req_ready,
  output logic            req_we,
  output logic            req_be,
  output logic [AW-1:0]   req_addr,
  output logic [IW-1:0]   req_tag,
  output logic [7:0]      req_wdata,
  input  logic            rsp_valid,
  input  logic [IW-1:0]   rsp_tag,
  input  logic [7:0]      rsp_data,
  input  logic [VLEN-1:0] src_vreg,
  output logic            dst_we,
  output logic [IW-1:0]   dst_idx,
  output logic [7:0]      dst_byte
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_DRAIN, S_FIN} st_t;

  st_t            st;
  logic           op_q;
  logic [AW-1:0]  base_q;
  logic [VSW-1:0] idx, last, tot, rcnt, vs_q;
  logic [VLW:0]   nb_wide;
  logic [VSW-1:0] nb_cur;
  logic           skip;
  logic [VSW-1:0] rcnt_nx;

  assign nb_wide = ({1'b0, vl} + (VLW+1)'(7)) >> 3;
  assign nb_cur  = (nb_wide > (VLW+1)'(NB)) ? VSW'(NB) : nb_wide[VSW-1:0];
  assign skip    = (vstart_in >= VSW'(NB)) || (vstart_in >= nb_cur);
  assign rcnt_nx = rcnt + VSW'(rsp_valid);

  assign busy       = (st != S_IDLE);
  assign done       = (st == S_FIN);
  assign vstart_out = vs_q;
  assign req_valid  = (st == S_ISSUE);
  assign req_we     = op_q;
  assign req_be     = req_valid;
  assign req_tag    = idx[IW-1:0];
  assign req_addr   = base_q + AW'(idx);
  assign req_wdata  = src_vreg[{req_tag, 3'b000} +: 8];
  assign dst_we     = rsp_valid && !op_q && (st == S_ISSUE || st == S_DRAIN);
  assign dst_idx    = rsp_tag;
  assign dst_byte   = rsp_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      op_q   <= 1'b0;
      base_q <= '0;
      idx    <= '0;
      last   <= '0;
      tot    <= '0;
      rcnt   <= '0;
      vs_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q   <= op_store;
          base_q <= base_addr;
          rcnt   <= '0;
          if (skip) begin
            vs_q <= '0;
            st   <= S_FIN;
          end else begin
            vs_q <= vstart_in;
            idx  <= vstart_in;
            last <= nb_cur - VSW'(1);
            tot  <= nb_cur - vstart_in;
            st   <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (!op_q) rcnt <= rcnt_nx;
          if (req_ready) begin
            if (idx == last) begin
              if (op_q) begin
                vs_q <= '0;
                st   <= S_FIN;
              end else begin
                st <= S_DRAIN;
              end
            end else begin
              idx <= idx + VSW'(1);
            end
          end
        end
        S_DRAIN: begin
          rcnt <= rcnt_nx;
          if (rcnt_nx == tot) begin
            vs_q <= '0;
            st   <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vmask_seq_chk.sv
module vmask_seq_chk #(
  parameter int AW = 64,
  parameter int VSW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           done,
  input logic [VSW-1:0] vstart_out,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_be,
  input logic [AW-1:0]  req_addr,
  input logic           dst_we
);

  logic          seen;
  logic [AW-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst || done) begin
      seen <= 1'b0;
      prev <= '0;
    end else if (req_valid && req_ready) begin
      seen <= 1'b1;
      prev <= req_addr;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    done |-> vstart_out == '0); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && seen |-> req_addr == prev + AW'(1)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid && !dst_we); // R10
  AST_BYTE_EN: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_be); // R6

endmodule

bind vmask_seq vmask_seq_chk #(.AW(AW), .VSW(VSW)) u_chk (.*);

// File: tb/sim_vmask_seq.sv
`timescale 1ns/1ps
module sim_vmask_seq;
  localparam int VLEN = 128;
  localparam int AW   = 64;
  localparam int NB   = VLEN / 8;

  logic clk = 0, rst = 1, start = 0, op_store = 0;
  logic [AW-1:0] base_addr = '0;
  logic [7:0] vl = '0;
  logic [4:0] vstart_in = '0;
  logic busy, done, req_valid, req_we, req_be, dst_we;
  logic req_ready = 0, rsp_valid = 0;
  logic [4:0] vstart_out;
  logic [AW-1:0] req_addr;
  logic [3:0] req_tag, dst_idx;
  logic [3:0] rsp_tag = '0;
  logic [7:0] req_wdata, dst_byte;
  logic [7:0] rsp_data = '0;
  logic [VLEN-1:0] src_vreg;

  always #2.5 clk = ~clk;

  vmask_seq #(.VLEN(VLEN), .AW(AW)) u0 (.*);

  int errs = 0, checks = 0, cyc = 0, overlap = 0;
  logic [7:0] mem [256];
  logic [7:0] regf [NB];
  logic [7:0] src [NB];
  int tagq[$], datq[$];
  bit cur_store = 0, pv = 0;
  logic [AW-1:0] cur_base = '0, pa = '0;
  int exp_idx = 0, hs_n = 0, rdy_mode = 0;

  always_comb for (int i = 0; i < NB; i++) src_vreg[i*8 +: 8] = src[i];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (dst_we) regf[dst_idx] <= dst_byte;
  end

  always @(negedge clk) begin
    if (rst) begin
      rsp_valid = 0; req_ready = 0; pv = 0;
      tagq.delete(); datq.delete();
    end else begin
      if (tagq.size() > 0 && (cyc % 3) != 1) begin
        rsp_valid = 1; rsp_tag = 4'(tagq.pop_front()); rsp_data = 8'(datq.pop_front());
      end else rsp_valid = 0;
      req_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      #1;
      if (rsp_valid)
        chk(dst_we && dst_idx == rsp_tag && dst_byte == rsp_data, "R5", "dst write",
            {dst_we, dst_idx, dst_byte}, {1'b1, rsp_tag, rsp_data});
      else if (dst_we) chk(0, "R5", "stray dst_we", 1, 0);
      if (pv) chk(req_valid && req_addr == pa, "R7", "hold", req_addr, pa);
      pv = req_valid && !req_ready;
      pa = req_addr;
      if (req_valid && req_ready) begin
        hs_n++;
        if (rsp_valid) overlap++;
        chk(req_addr == cur_base + AW'(exp_idx) && req_tag == 4'(exp_idx), "R2", "addr",
            req_addr, cur_base + AW'(exp_idx));
        chk(req_we == cur_store && req_be, "R6", "we/be", {req_we, req_be}, {cur_store, 1'b1});
        if (cur_store) begin
          chk(req_wdata == src[exp_idx], "R6", "wdata", req_wdata, src[exp_idx]);
          mem[req_addr[7:0]] = req_wdata;
        end else begin
          tagq.push_back(int'(req_tag));
          datq.push_back(int'(mem[req_addr[7:0]]));
        end
        exp_idx++;
      end
    end
  end

  task automatic run_op(bit st, logic [AW-1:0] base, int vlv, int vs, int rm, bit poke, string rq);
    int nb, cnt, k, bad;
    logic [7:0] er [NB];
    logic [7:0] em [256];
    nb = (vlv + 7) / 8;
    cnt = (vs >= NB || vs >= nb) ? 0 : nb - vs;
    for (int i = 0; i < NB; i++) er[i] = regf[i];
    for (int i = 0; i < 256; i++) em[i] = mem[i];
    for (int i = vs; i < vs + cnt; i++) begin
      if (st) em[8'(base + AW'(i))] = src[i];
      else er[i] = mem[8'(base + AW'(i))];
    end
    @(negedge clk);
    cur_store = st; cur_base = base; exp_idx = vs; hs_n = 0; rdy_mode = rm;
    start = 1; op_store = st; base_addr = base; vl = 8'(vlv); vstart_in = 5'(vs);
    @(negedge clk); #2;
    start = 0;
    if (cnt == 0) chk(done && !busy == 0 && vstart_out == 0, rq, "early done", done, 1);
    else chk(busy && !done && vstart_out == 5'(vs), "R8", "captured vstart", vstart_out, vs);
    if (poke && cnt > 2) begin
      start = 1; op_store = !st; base_addr = 64'h0; vl = 8'd128; vstart_in = 5'd0;
      @(negedge clk); #2;
      start = 0;
    end
    k = 0;
    while (!done && k < 3000) begin @(negedge clk); #2; k++; end
    chk(done, "R8", "done seen", done, 1);
    chk(vstart_out == 0, "R8", "vstart cleared", vstart_out, 0);
    chk(hs_n == cnt, poke ? "R9" : "R1", "request count", hs_n, cnt);
    @(negedge clk); #2;
    chk(!done && !busy, "R8", "done one cycle", done, 0);
    bad = 0;
    for (int i = 0; i < NB; i++) if (regf[i] !== er[i]) bad++;
    for (int i = 0; i < 256; i++) if (mem[i] !== em[i]) bad++;
    chk(bad == 0, st ? "R6" : "R5", "image compare mismatches", bad, 0);
  endtask

  bit finished = 0;
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < NB; i++) begin regf[i] = 8'(8'hA0 + i); src[i] = (i % 2 == 0) ? 8'h55 ^ 8'(i) : 8'hAA ^ 8'(i); end
    repeat (3) @(negedge clk);
    #2;
    chk(!busy && !done && !req_valid && vstart_out == 0, "R10", "reset state", {busy, done, req_valid}, 0);
    rst = 0;
    run_op(0, 64'h1234_0000_0000_0040, 11, 0, 0, 0, "R1");
    run_op(1, 64'h0000_0000_0000_0080, 11, 0, 0, 0, "R1");
    run_op(0, 64'h40, 11, 2, 0, 0, "R4");
    run_op(1, 64'h80, 11, 2, 0, 0, "R4");
    run_op(0, 64'h40, 0, 0, 0, 0, "R4");
    run_op(0, 64'h10, 128, 0, 3, 0, "R1");
    run_op(1, 64'hFFFF_0000_0000_00C0, 128, 5, 3, 0, "R2");
    run_op(0, 64'h20, 128, 16, 0, 0, "R3");
    run_op(1, 64'h20, 128, 20, 0, 0, "R3");
    run_op(0, 64'h60, 100, 3, 3, 1, "R9");
    run_op(1, 64'hA0, 1, 0, 3, 0, "R1");
    run_op(0, 64'h30, 57, 7, 0, 0, "R2");
    @(negedge clk);
    rdy_mode = 3; cur_store = 0; cur_base = 64'h10; exp_idx = 0;
    start = 1; op_store = 0; base_addr = 64'h10; vl = 8'd128; vstart_in = 0;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    rst = 1;
    @(negedge clk); #2;
    chk(!busy && !req_valid && !done && vstart_out == 0, "R10", "mid-op reset", {busy, req_valid}, 0);
    rst = 0;
    chk(overlap > 0, "R5", "writeback and issue in one cycle", overlap, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL R8 watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule